// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block takes one cache-line request at a time, with the bank, row and column already decoded, and turns it into the command stream a DRAM device expects. It keeps a record of which row, if any, each bank currently holds in its row buffer. From that record it classifies each request as a hit, a miss or a conflict. A hit is the wanted row already open. A miss is the bank holding no open row. A conflict is the bank holding a different row. The block then issues only the commands the request actually needs, so each of the three outcomes has its own, observable latency.

A configuration input selects the page policy for each request. With the open-page policy, the row stays in its row buffer after the burst. With the closed-page policy, the bank is precharged right after the burst. A refresh timer raises a refresh request periodically. Before the refresh command, the sequencer precharges every bank that is still open, and it accepts no new request until the refresh period has run out.

Each transfer is a burst of eight 64-bit beats, and every beat carries its own column command. Write data is taken from the requester beat by beat and passed straight to the device side. Read data from the device is passed back with a valid flag and a last-beat flag. When a request completes, the block reports its outcome and its latency.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `cmd_valid`, `done_valid`, `rd_valid` and `wr_ready` are all 0. Every bank is treated as having no open row.
- R2: A column command (op 2 = read, op 3 = write) is only ever issued to a bank whose row buffer holds the addressed row. That row was put there by an activate command (op 1).
- R3: A hit has the requested row already open in its bank. The first column command appears in the cycle after the accepting edge. Completion reports status 0 with latency BURST_LEN.
- R4: A miss arrives at a bank with no open row. The block issues an activate in the cycle after acceptance and the first column command T_RCD cycles later, with no precharge. Completion reports status 1 with latency BURST_LEN+T_RCD.
- R5: A conflict arrives at a bank that holds another row. The block issues a precharge (op 4) to that bank, an activate T_RP cycles later, and the first column command T_RCD cycles after that. Completion reports status 2 with latency BURST_LEN+T_RP+T_RCD. Alternating rows in one bank therefore conflict every time.
- R6: Every request is served as BURST_LEN column commands in consecutive cycles, with column = base column + beat index. Read beats raise `rd_valid` with `rd_data` equal to `dram_rdata`, and `rd_last` is set on the final beat. Write beats raise `wr_ready` and forward `wr_data` onto `dram_wdata`. `done_valid` coincides with the final beat.
- R7: If `cfg_close_page` was 1 when the request was accepted, a precharge to the same bank follows in the cycle after the final beat. `req_ready` stays low for T_RP cycles from that command. The bank is then idle, so a repeated request to it is a miss.
- R8: Every bank keeps its own open-row state. Opening or closing a row in one bank never changes how a later request to another bank is classified.
- R9: A refresh command (op 6) is issued once every REF_INTERVAL cycles. It is delayed by at most one request in progress plus the precharge before it.
- R10: If any bank is open when a refresh falls due, a precharge-all (op 5) is issued first and the refresh follows exactly T_RP cycles later. Afterwards every bank is closed. A precharge-all never occurs while no bank is open.
- R11: From a precharge-all or refresh command until T_RFC cycles after the refresh command, `req_ready` is 0 and no request command is issued. `req_ready` returns to 1 exactly T_RFC cycles after the refresh command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_close_page | input | 1 | Page policy sampled at acceptance: 1 = close after burst, 0 = leave open |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Base column of the burst |
| wr_data | input | DATA_W | Write beat from the requester |
| wr_ready | output | 1 | A write beat is taken in this cycle |
| rd_valid | output | 1 | A read beat is delivered in this cycle |
| rd_data | output | DATA_W | Read beat |
| rd_last | output | 1 | Final read beat of the burst |
| cmd_valid | output | 1 | Command on the device bus this cycle |
| cmd_op | output | 3 | 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh |
| cmd_bank | output | BANK_W | Command bank |
| cmd_row | output | ROW_W | Row for activate and column commands |
| cmd_col | output | COL_W | Column for read and write commands |
| dram_wdata | output | DATA_W | Write data to the device |
| dram_rdata | input | DATA_W | Read data from the device |
| done_valid | output | 1 | Request completes this cycle |
| done_status | output | 2 | 0 hit, 1 miss, 2 conflict |
| done_latency | output | LAT_W | Cycles from the accepting edge to completion, inclusive |

## Verification
The assertions check several rules on every cycle. A column command only reaches a bank whose table entry holds the same row. Completion always coincides with a column beat. A closed-page completion is always followed by a precharge to the same bank. No bank is open when a refresh is issued, and the request port is shut in the cycle after it. A pending refresh never disappears without a refresh command. The bench's scenarios are needed for the rest: that the classification follows the history of each bank, the exact command spacing and the latency ordering hit < miss < conflict, data integrity through the write and read paths, and the interval between refreshes.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_ACT  = 3'd1,
        OP_RD   = 3'd2,
        OP_WR   = 3'd3,
        OP_PRE  = 3'd4,
        OP_PREA = 3'd5,
        OP_REF  = 3'd6
    } cmd_op_e;

    typedef enum logic [1:0] {
        ACC_HIT      = 2'd0,
        ACC_MISS     = 2'd1,
        ACC_CONFLICT = 2'd2
    } acc_stat_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PRE,
        S_ACT,
        S_BURST,
        S_CLOSE,
        S_RPRE,
        S_RWAIT
    } seq_state_e;

endpackage

// File: rtl/dbs_refresh_timer.sv
module dbs_refresh_timer #(
    parameter int INTERVAL = 7800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_issue,
    output logic ref_pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (ref_issue) t_d.pend = 1'b0;
        if (t_q.cnt == CW'(INTERVAL - 1)) begin
            t_d.cnt  = '0;
            t_d.pend = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign ref_pending = t_q.pend;

    assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pending && !ref_issue) |=> ref_pending);

endmodule

// File: rtl/dbs_bank_table.sv
module dbs_bank_table #(
    parameter int NUM_BANKS = 16,
    parameter int ROW_W     = 16,
    localparam int BW       = $clog2(NUM_BANKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_en,
    input  logic [BW-1:0]    act_bank,
    input  logic [ROW_W-1:0] act_row,
    input  logic             pre_en,
    input  logic [BW-1:0]    pre_bank,
    input  logic             prea_en,
    input  logic [BW-1:0]    look_bank,
    output logic             look_open,
    output logic [ROW_W-1:0] look_row,
    input  logic [BW-1:0]    chk_bank,
    output logic             chk_open,
    output logic [ROW_W-1:0] chk_row,
    output logic             any_open
);
    logic [NUM_BANKS-1:0] open_vec;
    logic [ROW_W-1:0]     row_arr [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_d, open_q;
        logic [ROW_W-1:0] row_d, row_q;

        always_comb begin
            open_d = open_q;
            row_d  = row_q;
            if (prea_en) begin
                open_d = 1'b0;
            end else if (act_en && act_bank == BW'(b)) begin
                open_d = 1'b1;
                row_d  = act_row;
            end else if (pre_en && pre_bank == BW'(b)) begin
                open_d = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else begin
                open_q <= open_d;
                row_q  <= row_d;
            end
        end

        assign open_vec[b] = open_q;
        assign row_arr[b]  = row_q;
    end

    assign look_open = open_vec[look_bank];
    assign look_row  = row_arr[look_bank];
    assign chk_open  = open_vec[chk_bank];
    assign chk_row   = row_arr[chk_bank];
    assign any_open  = |open_vec;

    assert_one_update_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_en, pre_en, prea_en}));

    assert_pre_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |=> !open_vec[$past(pre_bank)]);

endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
    import dbs_pkg::*;
#(
    parameter int NUM_BANKS    = 16,
    parameter int ROW_W        = 16,
    parameter int COL_W        = 10,
    parameter int DATA_W       = 64,
    parameter int BURST_LEN    = 8,
    parameter int T_RCD        = 3,
    parameter int T_RP         = 3,
    parameter int T_RFC        = 8,
    parameter int REF_INTERVAL = 7800,
    parameter int LAT_W        = 16,
    localparam int BANK_W      = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_close_page,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_row,
    output logic [COL_W-1:0]  cmd_col,
    output logic [DATA_W-1:0] dram_wdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              done_valid,
    output logic [1:0]        done_status,
    output logic [LAT_W-1:0]  done_latency
);
    localparam int TMAX   = (T_RFC > T_RP) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                           : ((T_RP > T_RCD) ? T_RP : T_RCD);
    localparam int CNT_W  = $clog2(TMAX + 1);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BEAT_W-1:0] beat;
        logic              wr;
        logic              close;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        acc_stat_e         stat;
        logic [LAT_W-1:0]  lat;
        logic              cmd_v;
        cmd_op_e           op;
        logic [ROW_W-1:0]  crow;
        logic [COL_W-1:0]  ccol;
    } seq_t;

    seq_t r_q, r_d;

    logic             ref_pending, ref_issue;
    logic             look_open, chk_open, any_open;
    logic [ROW_W-1:0] look_row, chk_row;
    logic             last_beat;

    assign last_beat = (r_q.beat == BEAT_W'(BURST_LEN - 1));

    always_comb begin
        r_d       = r_q;
        r_d.cmd_v = 1'b0;
        r_d.op    = OP_NOP;
        r_d.lat   = r_q.lat + LAT_W'(1);
        unique case (r_q.st)
            S_IDLE: begin
                if (ref_pending) begin
                    r_d.cmd_v = 1'b1;
                    if (any_open) begin
                        r_d.op  = OP_PREA;
                        r_d.st  = S_RPRE;
                        r_d.cnt = CNT_W'(T_RP - 1);
                    end else begin
                        r_d.op  = OP_REF;
                        r_d.st  = S_RWAIT;
                        r_d.cnt = CNT_W'(T_RFC - 1);
                    end
                end else if (req_valid) begin
                    r_d.wr    = req_write;
                    r_d.close = cfg_close_page;
                    r_d.bank  = req_bank;
                    r_d.row   = req_row;
                    r_d.col   = req_col;
                    r_d.lat   = LAT_W'(1);
                    r_d.crow  = req_row;
                    r_d.cmd_v = 1'b1;
                    if (!look_open) begin
                        r_d.stat = ACC_MISS;
                        r_d.op   = OP_ACT;
                        r_d.st   = S_ACT;
                        r_d.cnt  = CNT_W'(T_RCD - 1);
                    end else if (look_row == req_row) begin
                        r_d.stat = ACC_HIT;
                        r_d.op   = req_write ? OP_WR : OP_RD;
                        r_d.st   = S_BURST;
                        r_d.beat = '0;
                        r_d.ccol = req_col;
                    end else begin
                        r_d.stat = ACC_CONFLICT;
                        r_d.op   = OP_PRE;
                        r_d.st   = S_PRE;
                        r_d.cnt  = CNT_W'(T_RP - 1);
                    end
                end
            end
            S_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd_v = 1'b1;
                    r_d.op    = OP_ACT;
                    r_d.st    = S_ACT;
                    r_d.cnt   = CNT_W'(T_RCD - 1);
                    r_d.crow  = r_q.row;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_ACT: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd_v = 1'b1;
                    r_d.op    = r_q.wr ? OP_WR : OP_RD;
                    r_d.st    = S_BURST;
                    r_d.beat  = '0;
                    r_d.ccol  = r_q.col;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_BURST: begin
                if (last_beat) begin
                    if (r_q.close) begin
                        r_d.cmd_v = 1'b1;
                        r_d.op    = OP_PRE;
                        r_d.st    = S_CLOSE;
                        r_d.cnt   = CNT_W'(T_RP - 1);
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end else begin
                    r_d.cmd_v = 1'b1;
                    r_d.op    = r_q.wr ? OP_WR : OP_RD;
                    r_d.beat  = r_q.beat + BEAT_W'(1);
                    r_d.ccol  = r_q.col + COL_W'(r_q.beat) + COL_W'(1);
                end
            end
            S_RPRE: begin
                if (r_q.cnt == '0) begin
                    r_d.cmd_v = 1'b1;
                    r_d.op    = OP_REF;
                    r_d.st    = S_RWAIT;
                    r_d.cnt   = CNT_W'(T_RFC - 1);
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            S_CLOSE, S_RWAIT: begin
                if (r_q.cnt == '0) r_d.st = S_IDLE;
                else               r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.op   <= OP_NOP;
            r_q.stat <= ACC_HIT;
        end else begin
            r_q <= r_d;
        end
    end

    assign ref_issue = r_d.cmd_v && (r_d.op == OP_REF);

    dbs_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_issue   (ref_issue),
        .ref_pending (ref_pending)
    );

    dbs_bank_table #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_en    (r_d.cmd_v && r_d.op == OP_ACT),
        .act_bank  (r_d.bank),
        .act_row   (r_d.crow),
        .pre_en    (r_d.cmd_v && r_d.op == OP_PRE),
        .pre_bank  (r_d.bank),
        .prea_en   (r_d.cmd_v && r_d.op == OP_PREA),
        .look_bank ((r_q.st == S_IDLE) ? req_bank : r_q.bank),
        .look_open (look_open),
        .look_row  (look_row),
        .chk_bank  (r_q.bank),
        .chk_open  (chk_open),
        .chk_row   (chk_row),
        .any_open  (any_open)
    );

    assign req_ready    = (r_q.st == S_IDLE) && !ref_pending;
    assign cmd_valid    = r_q.cmd_v;
    assign cmd_op       = r_q.op;
    assign cmd_bank     = r_q.bank;
    assign cmd_row      = r_q.crow;
    assign cmd_col      = r_q.ccol;
    assign wr_ready     = (r_q.st == S_BURST) && r_q.wr;
    assign dram_wdata   = wr_data;
    assign rd_valid     = (r_q.st == S_BURST) && !r_q.wr;
    assign rd_data      = dram_rdata;
    assign rd_last      = rd_valid && last_beat;
    assign done_valid   = (r_q.st == S_BURST) && last_beat;
    assign done_status  = r_q.stat;
    assign done_latency = r_q.lat;

    assert_col_row_open_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)) |-> (chk_open && chk_row == cmd_row));

    assert_done_on_column_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)));

    assert_close_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && r_q.close) |=> (cmd_valid && cmd_op == OP_PRE && $stable(cmd_bank)));

    assert_ref_all_closed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_REF) |-> !any_open);

    assert_ref_holdoff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_REF) |=> !req_ready);

endmodule

// File: tb/dram_bank_seq_bench.sv
module dram_bank_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB    = 16;
    localparam int RW    = 16;
    localparam int CW    = 10;
    localparam int DW    = 64;
    localparam int BL    = 8;
    localparam int TRCD  = 3;
    localparam int TRP   = 2;
    localparam int TRFC  = 6;
    localparam int RINT  = 400;
    localparam int SLACK = 40;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_close_page = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [3:0] req_bank = '0;
    logic [RW-1:0] req_row = '0;
    logic [CW-1:0] req_col = '0;
    logic [DW-1:0] wr_data, dram_rdata, rd_data, dram_wdata;
    logic req_ready, wr_ready, rd_valid, rd_last, cmd_valid, done_valid;
    logic [2:0] cmd_op;
    logic [3:0] cmd_bank;
    logic [RW-1:0] cmd_row;
    logic [CW-1:0] cmd_col;
    logic [1:0] done_status;
    logic [15:0] done_latency;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_bank_seq #(
        .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .BURST_LEN(BL),
        .T_RCD(TRCD), .T_RP(TRP), .T_RFC(TRFC), .REF_INTERVAL(RINT), .LAT_W(16)
    ) u_dram_bank_seq (
        .clk(clk), .rst_n(rst_n), .cfg_close_page(cfg_close_page),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .wr_data(wr_data), .wr_ready(wr_ready), .rd_valid(rd_valid),
        .rd_data(rd_data), .rd_last(rd_last), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata), .done_valid(done_valid),
        .done_status(done_status), .done_latency(done_latency)
    );

    int vecs = 0;
    int errs = 0;
    int cyc = 0;
    bit finished = 0;
    bit mon_on = 0;

    typedef struct { int cyc; int op; int bank; int row; int col; logic [DW-1:0] data; bit last; } ecmd_t;
    typedef struct { int cyc; int stat; int lat; } edone_t;
    ecmd_t  cq[$];
    edone_t dq[$];

    bit mopen[NB];
    int mrow[NB];
    logic [DW-1:0] dev_mem[int];
    logic [DW-1:0] exp_mem[int];
    logic [DW-1:0] wseed = 64'h0123_4567_89AB_CDEF;
    int last_ref = 0;
    int prea_cyc = -1;
    int ref_cyc = -1000;
    int ref_cnt = 0;
    int last_lat = 0;

    function automatic int mkey(int b, int r, int c);
        return (b << 26) | (r << 10) | (c & 1023);
    endfunction

    function automatic logic [DW-1:0] pat(int b, int r, int c, logic [DW-1:0] s);
        return {16'(b), 16'(r), 16'(c), 16'h5A5A} ^ s;
    endfunction

    function automatic logic [DW-1:0] dflt(int k);
        return 64'hDEAD_BEEF_0000_0000 | 64'(k);
    endfunction

    assign wr_data = wr_ready ? pat(int'(cmd_bank), int'(cmd_row), int'(cmd_col), wseed) : '0;

    always @(cmd_valid, cmd_op, cmd_bank, cmd_row, cmd_col) begin
        int k;
        k = mkey(int'(cmd_bank), int'(cmd_row), int'(cmd_col));
        if (cmd_valid && cmd_op == 3'd2) dram_rdata = dev_mem.exists(k) ? dev_mem[k] : dflt(k);
        else                            dram_rdata = '0;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && cmd_valid && cmd_op == 3'd3)
            dev_mem[mkey(int'(cmd_bank), int'(cmd_row), int'(cmd_col))] = dram_wdata;
    end

    task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the expected command, data and completion queues
    always @(negedge clk) begin
        if (mon_on) begin
            while (cq.size() != 0 && cq[0].cyc < cyc) begin
                chk(0, "R6", "missing command", '0, 64'(cq[0].op));
                void'(cq.pop_front());
            end
            if (cq.size() != 0 && cq[0].cyc == cyc) begin
                ecmd_t e;
                e = cq.pop_front();
                chk(cmd_valid && int'(cmd_op) == e.op, "R2", "command op", 64'(cmd_op), 64'(e.op));
                chk(int'(cmd_bank) == e.bank, "R8", "command bank", 64'(cmd_bank), 64'(e.bank));
                if (e.op == 1 || e.op == 2 || e.op == 3)
                    chk(int'(cmd_row) == e.row, "R2", "command row", 64'(cmd_row), 64'(e.row));
                if (e.op == 2 || e.op == 3)
                    chk(int'(cmd_col) == e.col, "R6", "column", 64'(cmd_col), 64'(e.col));
                if (e.op == 2) begin
                    chk(rd_valid && !wr_ready, "R6", "read beat valid", 64'(rd_valid), 64'd1);
                    chk(rd_data == e.data, "R6", "read data", rd_data, e.data);
                    chk(rd_last == e.last, "R6", "read last flag", 64'(rd_last), 64'(e.last));
                end
                if (e.op == 3)
                    chk(wr_ready && !rd_valid, "R6", "write beat ready", 64'(wr_ready), 64'd1);
            end else begin
                chk(!rd_valid && !wr_ready, "R6", "beat outside burst", 64'({rd_valid, wr_ready}), 64'd0);
                if (cmd_valid && cmd_op == 3'd5) begin
                    bit any;
                    any = 0;
                    foreach (mopen[i]) any |= mopen[i];
                    chk(any, "R10", "precharge-all with no open bank", 64'(any), 64'd1);
                    foreach (mopen[i]) mopen[i] = 0;
                    prea_cyc = cyc;
                end else if (cmd_valid && cmd_op == 3'd6) begin
                    bit any;
                    any = 0;
                    foreach (mopen[i]) any |= mopen[i];
                    chk(!any, "R10", "refresh with open bank", 64'(any), 64'd0);
                    if (prea_cyc >= 0)
                        chk(cyc == prea_cyc + TRP, "R10", "precharge-all to refresh gap",
                            64'(cyc - prea_cyc), 64'(TRP));
                    chk(cyc - last_ref <= RINT + SLACK, "R9", "refresh interval",
                        64'(cyc - last_ref), 64'(RINT));
                    last_ref = cyc;
                    ref_cyc = cyc;
                    prea_cyc = -1;
                    ref_cnt++;
                end else begin
                    chk(!cmd_valid, "R11", "unexpected command", 64'(cmd_op), 64'd0);
                end
            end
            if (prea_cyc >= 0 || (cyc >= ref_cyc && cyc < ref_cyc + TRFC))
                chk(!req_ready, "R11", "ready during refresh", 64'(req_ready), 64'd0);
            if (cyc == ref_cyc + TRFC)
                chk(req_ready, "R11", "ready after refresh", 64'(req_ready), 64'd1);
            while (dq.size() != 0 && dq[0].cyc < cyc) begin
                chk(0, "R6", "missing completion", '0, 64'(dq[0].lat));
                void'(dq.pop_front());
            end
            if (dq.size() != 0 && dq[0].cyc == cyc) begin
                edone_t d;
                d = dq.pop_front();
                chk(done_valid, "R6", "completion strobe", 64'(done_valid), 64'd1);
                chk(int'(done_status) == d.stat,
                    (d.stat == 0) ? "R3" : (d.stat == 1) ? "R4" : "R5",
                    "status", 64'(done_status), 64'(d.stat));
                chk(int'(done_latency) == d.lat,
                    (d.stat == 0) ? "R3" : (d.stat == 1) ? "R4" : "R5",
                    "latency", 64'(done_latency), 64'(d.lat));
                last_lat = int'(done_latency);
            end else if (done_valid) begin
                chk(0, "R6", "unexpected completion", 64'd1, 64'd0);
            end
        end
    end

    task automatic drain();
        while (cq.size() != 0 || dq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(bit w, int b, int r, int c, output int stat_o);
        int a, s, stat, k;
        @(negedge clk);
        if (w) wseed = {wseed[62:0], wseed[63] ^ wseed[60]};
        req_valid = 1'b1;
        req_write = w;
        req_bank  = 4'(b);
        req_row   = RW'(r);
        req_col   = CW'(c);
        while (!req_ready) @(negedge clk);
        a = cyc + 1;
        if (!mopen[b]) begin
            stat = 1;
            cq.push_back('{a, 1, b, r, 0, '0, 0});
            s = a + TRCD;
        end else if (mrow[b] == r) begin
            stat = 0;
            s = a;
        end else begin
            stat = 2;
            cq.push_back('{a, 4, b, 0, 0, '0, 0});
            cq.push_back('{a + TRP, 1, b, r, 0, '0, 0});
            s = a + TRP + TRCD;
        end
        for (int i = 0; i < BL; i++) begin
            k = mkey(b, r, c + i);
            if (w) exp_mem[k] = pat(b, r, (c + i) & 1023, wseed);
            cq.push_back('{s + i, w ? 3 : 2, b, r, (c + i) & 1023,
                           exp_mem.exists(k) ? exp_mem[k] : dflt(k), i == BL - 1});
        end
        dq.push_back('{s + BL - 1, stat, s + BL - a});
        if (cfg_close_page) begin
            cq.push_back('{s + BL, 4, b, 0, 0, '0, 0});
            mopen[b] = 0;
        end else begin
            mopen[b] = 1;
            mrow[b] = r;
        end
        stat_o = stat;
        @(negedge clk);
        req_valid = 1'b0;
        drain();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int st, l_hit, l_miss, l_conf;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(!cmd_valid && !done_valid, "R1", "idle bus after reset",
            64'({cmd_valid, done_valid}), 64'd0);
        chk(!rd_valid && !wr_ready, "R1", "no beats after reset", 64'({rd_valid, wr_ready}), 64'd0);
        last_ref = cyc;
        mon_on = 1;

        // Open-page policy: miss, hit, conflict on bank 3 (R3, R4, R5, R6)
        issue(1, 3, 16'h0010, 0, st);
        chk(st == 1, "R4", "first access classified", 64'(st), 64'd1);
        l_miss = last_lat;
        issue(0, 3, 16'h0010, 0, st);
        l_hit = last_lat;
        issue(0, 3, 16'h0020, 8, st);
        l_conf = last_lat;
        chk(l_hit < l_miss && l_miss < l_conf, "R5", "latency ordering hit<miss<conflict",
            64'({l_hit[15:0], l_miss[15:0], l_conf[15:0]}), 64'd0);
        // alternating rows: repeated conflicts (R5)
        issue(0, 3, 16'h0010, 0, st);
        issue(0, 3, 16'h0020, 8, st);
        chk(st == 2, "R5", "alternating rows conflict", 64'(st), 64'd2);

        // Bank independence (R8)
        issue(1, 5, 16'h0010, 16, st);
        issue(0, 3, 16'h0020, 8, st);
        chk(st == 0, "R8", "bank 3 stays open after bank 5 activity", 64'(st), 64'd0);
        issue(1, 15, 16'hFFFF, 1016, st);
        issue(0, 15, 16'hFFFF, 1016, st);
        issue(0, 5, 16'h0010, 16, st);
        chk(st == 0, "R8", "bank 5 row kept", 64'(st), 64'd0);

        // Closed-page policy (R7)
        cfg_close_page = 1'b1;
        issue(0, 3, 16'h0020, 8, st);
        issue(0, 3, 16'h0020, 8, st);
        chk(st == 1, "R7", "same row after close is a miss", 64'(st), 64'd1);
        issue(1, 7, 16'h0100, 24, st);
        issue(0, 7, 16'h0100, 24, st);
        cfg_close_page = 1'b0;

        // Refresh with banks open (R9, R10, R11)
        issue(0, 9, 16'h0042, 0, st);
        repeat (RINT + 20) @(negedge clk);
        chk(ref_cnt >= 1, "R9", "refresh seen while idle", 64'(ref_cnt), 64'd1);
        issue(0, 9, 16'h0042, 0, st);
        chk(st == 1, "R10", "bank closed by refresh", 64'(st), 64'd1);

        // Traffic across a refresh boundary
        for (int i = 0; i < 40; i++) begin
            issue(i[0], (i * 5) % NB, (i % 3) * 7, (i % 4) * 8, st);
        end
        repeat (RINT) @(negedge clk);
        chk(cyc - last_ref <= RINT + SLACK, "R9", "refresh keeps occurring",
            64'(cyc - last_ref), 64'(RINT));
        drain();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule